// File: doc/BRIEF.md
# Clock Frequency Accuracy Monitor

This block judges whether a target clock runs at its intended rate. It counts ticks of a prescaled target clock across one period of a reference signal. On every qualifying reference edge it stores the count in a read-only buffer and compares that value with a programmable lower and upper bound. The reference is either a filtered external pin or a divided internal clock. Both the target and the reference sources arrive as clock-enable strobes or levels inside a single system clock domain.

Software drives the block through a byte-wide register port. Three sticky flags report a frequency error, the end of a measurement and a counter wrap. Each flag is cleared by writing one to its own bit. Each flag drives an interrupt output through its own enable bit.

A three-state controller sequences a measurement. From **IDLE**, transition GO moves to **ARM** once the run bit is set. In **ARM**, transition ARMED moves to **RUN** on the first qualifying edge, which only starts the count. In **RUN**, transition CAPTURE stays in **RUN** on every further qualifying edge. Transition STOP returns any state to **IDLE** when the run bit is cleared.

Register map (`reg_addr`):
- 0: run control. Bit 0 starts the block.
- 1: source setup. [1:0] is the target divide, [3:2] the edge select, bit 4 the reference select and bit 5 the pin enable.
- 2: reference setup. [1:0] is the reference divide and [3:2] the filter code.
- 3: interrupt enables.
- 4: status flags (read only).
- 5: flag clear (write only, reads 0).
- 6, 7: upper bound, low byte then high byte.
- 8, 9: lower bound, low byte then high byte.
- 10, 11: captured count (read only), low byte then high byte.

Top module: `freq_mon`

## Requirements
- R1: After reset every register reads 0, the controller is in IDLE and all three interrupt outputs are low.
- R2: The target divide field (address 1, bits [1:0]) makes one count tick per 1, 4, 8 or 32 target strobes for codes 00, 01, 10 and 11.
- R3: The edge field (address 1, bits [3:2]) qualifies rising edges (00), falling edges (01) or both edges (10). Code 11 qualifies no edge, so no capture occurs.
- R4: The first qualifying edge after starting only arms the count. Each later edge loads the buffer with the number of ticks in the period just ended, and the count restarts. A tick that lands in the edge cycle goes to the new period.
- R5: At each capture, status bit 0 (frequency error) is set if the count is above the upper bound or below the lower bound. A count equal to either bound is in range.
- R6: Status bit 1 (measurement end) is set by every capture.
- R7: Status bit 2 (overflow) is set when the count wraps from 0xFFFF to 0.
- R8: Writing address 5 clears each status flag whose bit is 1. Bits written as 0 leave their flags unchanged.
- R9: Each interrupt output equals its flag AND its enable bit at address 3: bit 0 frequency error, bit 1 measurement end, bit 2 overflow.
- R10: Address 1 bit 4 set selects the internal reference, whose period is 32, 128, 1024 or 8192 reference strobes for address 2 bits [1:0] = 00, 01, 10 and 11. Bit 4 clear selects the pin, which is seen only when address 1 bit 5 is set.
- R11: With address 2 bits [3:2] = 00 the filter is bypassed. Codes 01, 10 and 11 sample the reference every 1, 4 or 16 clocks and accept a new level only after three equal consecutive samples.
- R12: Clearing the run bit resets the count, both prescalers, the filter and the edge detector, and returns to IDLE. The flags and the captured count are kept.
- R13: Configuration and bound registers read back as written. Writes to the read-only addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_ce | input | 1 | One strobe per target clock cycle |
| ref_ce | input | 1 | One strobe per internal reference clock cycle |
| ref_pin | input | 1 | External reference level, already in clk domain |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_ferr | output | 1 | Frequency error interrupt |
| irq_mend | output | 1 | Measurement end interrupt |
| irq_ovf | output | 1 | Counter overflow interrupt |

## Verification
The assertions take it that `ref_pin` is already synchronous to `clk`. They also take it that reset is asserted long enough to clear every register. The stimulus drives all inputs on the falling clock edge, so no input changes near the sampling edge. It changes the configuration only while the run bit is clear, so every measured period uses a single prescaler and filter setting. Pin waveforms use periods that are whole multiples of the target divide and of the filter sample interval. This makes each expected count exact and independent of the phase at which the block was started.

// File: rtl/freq_mon_pkg.sv
package freq_mon_pkg;

    localparam int ADDR_W     = 4;
    localparam int BYTE_W     = 8;
    localparam int CNT_W      = 2 * BYTE_W;
    localparam int TGT_PRE_W  = 5;
    localparam int REF_PRE_W  = 13;
    localparam int FILT_CNT_W = 4;
    localparam int REF_IDX_W  = $clog2(REF_PRE_W);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } fm_state_e;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_SRC  = 4'd1;
    localparam logic [ADDR_W-1:0] A_REF  = 4'd2;
    localparam logic [ADDR_W-1:0] A_IEN  = 4'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd4;
    localparam logic [ADDR_W-1:0] A_CLR  = 4'd5;
    localparam logic [ADDR_W-1:0] A_UPL  = 4'd6;
    localparam logic [ADDR_W-1:0] A_UPH  = 4'd7;
    localparam logic [ADDR_W-1:0] A_LOL  = 4'd8;
    localparam logic [ADDR_W-1:0] A_LOH  = 4'd9;
    localparam logic [ADDR_W-1:0] A_CAPL = 4'd10;
    localparam logic [ADDR_W-1:0] A_CAPH = 4'd11;

    // low-bit mask: a tick fires when all masked prescaler bits are one
    function automatic logic [TGT_PRE_W-1:0] tgt_mask(input logic [1:0] code);
        case (code)
            2'b00:   return TGT_PRE_W'(0);
            2'b01:   return TGT_PRE_W'(3);
            2'b10:   return TGT_PRE_W'(7);
            default: return TGT_PRE_W'(31);
        endcase
    endfunction

    // prescaler bit used as the divided reference level
    function automatic logic [REF_IDX_W-1:0] ref_bit(input logic [1:0] code);
        case (code)
            2'b00:   return REF_IDX_W'(4);
            2'b01:   return REF_IDX_W'(6);
            2'b10:   return REF_IDX_W'(9);
            default: return REF_IDX_W'(12);
        endcase
    endfunction

    function automatic logic [FILT_CNT_W-1:0] filt_mask(input logic [1:0] code);
        case (code)
            2'b10:   return FILT_CNT_W'(3);
            2'b11:   return FILT_CNT_W'(15);
            default: return FILT_CNT_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/fm_divider.sv
module fm_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ce,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (ce)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/fm_ref_cond.sv
module fm_ref_cond
    import freq_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       din,
    input  logic [1:0] fcode,
    input  logic [1:0] edge_sel,
    output logic       vedge
);

    logic [FILT_CNT_W-1:0] fcnt;
    logic [FILT_CNT_W-1:0] fmask;
    logic                  strobe;
    logic [1:0]            samp;
    logic                  lvl;
    logic                  prev;
    logic                  rise;
    logic                  fall;

    assign fmask  = filt_mask(fcode);
    assign strobe = ((fcnt & fmask) == fmask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcnt <= '0;
            samp <= '0;
            lvl  <= 1'b0;
            prev <= 1'b0;
        end else if (clr) begin
            fcnt <= '0;
            samp <= '0;
            lvl  <= 1'b0;
            prev <= 1'b0;
        end else begin
            fcnt <= fcnt + 1'b1;
            prev <= lvl;
            if (fcode == 2'b00) begin
                lvl <= din;
            end else if (strobe) begin
                samp <= {samp[0], din};
                if ((din == samp[0]) && (din == samp[1]))
                    lvl <= din;
            end
        end
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;

    always_comb begin
        vedge = 1'b0;
        unique case (edge_sel)
            2'b00:   vedge = rise;
            2'b01:   vedge = fall;
            2'b10:   vedge = rise | fall;
            default: vedge = 1'b0;
        endcase
    end

    // R11
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (fcode != 2'b00) && !strobe) |=> $stable(lvl));

endmodule

// File: rtl/freq_mon.sv
module freq_mon
    import freq_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tgt_ce,
    input  logic              ref_ce,
    input  logic              ref_pin,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq_ferr,
    output logic              irq_mend,
    output logic              irq_ovf
);

    fm_state_e            state_q, state_d;
    logic                 en_q, rsel_q, pin_en_q;
    logic [1:0]           tdiv_q, edg_q, rdiv_q, fcode_q;
    logic [2:0]           ien_q;
    logic [CNT_W-1:0]     up_q, lo_q, cap_q, cnt_q;
    logic                 flag_ferr, flag_mend, flag_ovf;
    logic                 clr;
    logic [TGT_PRE_W-1:0] tcnt, tmask;
    logic [REF_PRE_W-1:0] rcnt;
    logic                 ttick, ref_int, ref_src, vedge;

    assign clr = ~en_q;

    fm_divider #(.W(TGT_PRE_W)) u_tgt_div (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ce(tgt_ce), .cnt(tcnt)
    );

    fm_divider #(.W(REF_PRE_W)) u_ref_div (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ce(ref_ce), .cnt(rcnt)
    );

    assign tmask   = tgt_mask(tdiv_q);
    assign ttick   = tgt_ce && ((tcnt & tmask) == tmask);
    assign ref_int = rcnt[ref_bit(rdiv_q)];
    assign ref_src = rsel_q ? ref_int : (ref_pin & pin_en_q);

    fm_ref_cond u_cond (
        .clk(clk), .rst_n(rst_n), .clr(clr), .din(ref_src),
        .fcode(fcode_q), .edge_sel(edg_q), .vedge(vedge)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transitions: GO, ARMED, CAPTURE, STOP
    always_comb begin
        state_d = state_q;
        if (!en_q) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_ARM;
                ST_ARM:  if (vedge) state_d = ST_RUN;
                ST_RUN:  state_d = ST_RUN;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs: registers, counter, capture and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0; rsel_q <= 1'b0; pin_en_q <= 1'b0;
            tdiv_q <= '0; edg_q <= '0; rdiv_q <= '0; fcode_q <= '0;
            ien_q <= '0; up_q <= '0; lo_q <= '0; cap_q <= '0; cnt_q <= '0;
            flag_ferr <= 1'b0; flag_mend <= 1'b0; flag_ovf <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    A_CTRL: en_q <= reg_wdata[0];
                    A_SRC: begin
                        tdiv_q   <= reg_wdata[1:0];
                        edg_q    <= reg_wdata[3:2];
                        rsel_q   <= reg_wdata[4];
                        pin_en_q <= reg_wdata[5];
                    end
                    A_REF: begin
                        rdiv_q  <= reg_wdata[1:0];
                        fcode_q <= reg_wdata[3:2];
                    end
                    A_IEN: ien_q <= reg_wdata[2:0];
                    A_CLR: begin
                        if (reg_wdata[0]) flag_ferr <= 1'b0;
                        if (reg_wdata[1]) flag_mend <= 1'b0;
                        if (reg_wdata[2]) flag_ovf  <= 1'b0;
                    end
                    A_UPL: up_q[BYTE_W-1:0]     <= reg_wdata;
                    A_UPH: up_q[CNT_W-1:BYTE_W] <= reg_wdata;
                    A_LOL: lo_q[BYTE_W-1:0]     <= reg_wdata;
                    A_LOH: lo_q[CNT_W-1:BYTE_W] <= reg_wdata;
                    default: ;
                endcase
            end
            if (!en_q) begin
                cnt_q <= '0;
            end else begin
                unique case (state_q)
                    ST_ARM: cnt_q <= CNT_W'(vedge && ttick);
                    ST_RUN: begin
                        if (vedge) begin
                            cap_q     <= cnt_q;
                            cnt_q     <= CNT_W'(ttick);
                            flag_mend <= 1'b1;
                            if ((cnt_q > up_q) || (cnt_q < lo_q))
                                flag_ferr <= 1'b1;
                        end else if (ttick) begin
                            cnt_q <= cnt_q + 1'b1;
                            if (&cnt_q)
                                flag_ovf <= 1'b1;
                        end
                    end
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {7'b0, en_q};
            A_SRC:   reg_rdata = {2'b0, pin_en_q, rsel_q, edg_q, tdiv_q};
            A_REF:   reg_rdata = {4'b0, fcode_q, rdiv_q};
            A_IEN:   reg_rdata = {5'b0, ien_q};
            A_STAT:  reg_rdata = {5'b0, flag_ovf, flag_mend, flag_ferr};
            A_UPL:   reg_rdata = up_q[BYTE_W-1:0];
            A_UPH:   reg_rdata = up_q[CNT_W-1:BYTE_W];
            A_LOL:   reg_rdata = lo_q[BYTE_W-1:0];
            A_LOH:   reg_rdata = lo_q[CNT_W-1:BYTE_W];
            A_CAPL:  reg_rdata = cap_q[BYTE_W-1:0];
            A_CAPH:  reg_rdata = cap_q[CNT_W-1:BYTE_W];
            default: reg_rdata = '0;
        endcase
    end

    assign irq_ferr = flag_ferr & ien_q[0];
    assign irq_mend = flag_mend & ien_q[1];
    assign irq_ovf  = flag_ovf  & ien_q[2];

    // R4
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> ($past(state_q) != ST_IDLE));

    // R12
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (state_q == ST_IDLE));

    // R7
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_ovf) |-> (&$past(cnt_q)));

    // R6
    mend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_mend) |-> ($past(state_q) == ST_RUN));

    // R5
    ferr_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_ferr) |-> ((cap_q > $past(up_q)) || (cap_q < $past(lo_q))));

endmodule

// File: tb/tb_freq_mon.sv
`timescale 1ns/1ps
module tb_freq_mon;

    localparam logic [3:0] T_CTRL = 4'd0, T_SRC = 4'd1, T_REF = 4'd2, T_IEN = 4'd3;
    localparam logic [3:0] T_STAT = 4'd4, T_CLR = 4'd5, T_UPL = 4'd6, T_UPH = 4'd7;
    localparam logic [3:0] T_LOL = 4'd8, T_LOH = 4'd9, T_CAPL = 4'd10, T_CAPH = 4'd11;
    localparam int WATCHDOG = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tgt_ce = 1'b1;
    logic       ref_ce = 1'b1;
    logic       ref_pin = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_ferr, irq_mend, irq_ovf;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    freq_mon dut (
        .clk(clk), .rst_n(rst_n), .tgt_ce(tgt_ce), .ref_ce(ref_ce), .ref_pin(ref_pin),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ferr(irq_ferr), .irq_mend(irq_mend), .irq_ovf(irq_ovf)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog req=all act=%0d exp<%0d", cyc, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_cap(output int v);
        logic [7:0] lo8, hi8;
        rd(T_CAPL, lo8);
        rd(T_CAPH, hi8);
        v = int'({hi8, lo8});
    endtask

    task automatic setup(input logic [7:0] src, input logic [7:0] refb,
                         input logic [15:0] up, input logic [15:0] lo);
        wr(T_CTRL, 8'h00);
        wr(T_CLR, 8'h07);
        wr(T_SRC, src);
        wr(T_REF, refb);
        wr(T_UPL, up[7:0]); wr(T_UPH, up[15:8]);
        wr(T_LOL, lo[7:0]); wr(T_LOH, lo[15:8]);
        ref_pin = 1'b0;
        wr(T_CTRL, 8'h01);
        idle(4);
    endtask

    task automatic meas(input logic [7:0] src, input logic [7:0] refb,
                        input logic [15:0] up, input logic [15:0] lo,
                        input int per, input int nper, input bit use_pin);
        setup(src, refb, up, lo);
        for (int i = 0; i < nper; i++) begin
            if (use_pin) begin
                ref_pin = 1'b1; idle(per / 2);
                ref_pin = 1'b0; idle(per / 2);
            end else begin
                idle(per);
            end
        end
        idle(40);
    endtask

    // {tdiv, edge, upper, lower, period, exp_cap, exp_ferr, exp_mend}
    localparam logic [69:0] VEC [0:6] = '{
        {2'd0, 2'd0, 16'd50, 16'd30, 16'd40,  16'd40, 1'b0, 1'b1},
        {2'd0, 2'd1, 16'd39, 16'd0,  16'd40,  16'd40, 1'b1, 1'b1},
        {2'd1, 2'd0, 16'd16, 16'd16, 16'd64,  16'd16, 1'b0, 1'b1},
        {2'd2, 2'd2, 16'd3,  16'd0,  16'd64,  16'd4,  1'b1, 1'b1},
        {2'd3, 2'd0, 16'd10, 16'd5,  16'd128, 16'd4,  1'b1, 1'b1},
        {2'd0, 2'd2, 16'd10, 16'd10, 16'd20,  16'd10, 1'b0, 1'b1},
        {2'd0, 2'd3, 16'd0,  16'd0,  16'd40,  16'd10, 1'b0, 1'b0}
    };

    initial begin
        logic [7:0] d;
        int cap;

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(T_STAT, d); chk("R1 status", int'(d), 0);
        rd(T_CTRL, d); chk("R1 control", int'(d), 0);
        rd_cap(cap);   chk("R1 capture", cap, 0);
        chk("R1 irq", int'({irq_ferr, irq_mend, irq_ovf}), 0);

        // R13 map
        wr(T_UPH, 8'hA5); rd(T_UPH, d); chk("R13 upper hi readback", int'(d), 8'hA5);
        wr(T_STAT, 8'hFF); rd(T_STAT, d); chk("R13 status write ignored", int'(d), 0);
        wr(T_CAPL, 8'h5A); rd(T_CAPL, d); chk("R13 capture write ignored", int'(d), 0);

        // table walk: R2 / R3 / R4 / R5 / R6
        for (int i = 0; i < 7; i++) begin
            logic [69:0] v;
            v = VEC[i];
            meas({2'b00, 1'b1, 1'b0, v[67:66], v[69:68]}, 8'h00,
                 v[65:50], v[49:34], int'(v[33:18]), 3, 1'b1);
            rd_cap(cap);
            chk($sformatf("R2/R3/R4 capture vec%0d", i), cap, int'(v[17:2]));
            rd(T_STAT, d);
            chk($sformatf("R5 ferr vec%0d", i), int'(d[0]), int'(v[1]));
            chk($sformatf("R6 mend vec%0d", i), int'(d[1]), int'(v[0]));
        end

        // R8 / R9 write-one-to-clear and interrupt gating
        meas(8'h20, 8'h00, 16'd5, 16'd0, 40, 3, 1'b1);
        rd(T_STAT, d); chk("R5 ferr above upper", int'(d), 3);
        wr(T_CLR, 8'h00); rd(T_STAT, d); chk("R8 zero write no effect", int'(d), 3);
        wr(T_CLR, 8'h01); rd(T_STAT, d); chk("R8 clear ferr only", int'(d), 2);
        wr(T_IEN, 8'h00); chk("R9 mend irq masked", int'(irq_mend), 0);
        wr(T_IEN, 8'h07);
        chk("R9 mend irq enabled", int'(irq_mend), 1);
        chk("R9 ferr irq cleared flag", int'(irq_ferr), 0);
        wr(T_CLR, 8'h02); chk("R8 R9 mend cleared irq low", int'(irq_mend), 0);
        wr(T_IEN, 8'h00);

        // R10 internal reference and pin gating
        meas(8'h10, 8'h00, 16'hFFFF, 16'd0, 32, 6, 1'b0);
        rd_cap(cap); chk("R10 internal /32", cap, 32);
        meas(8'h10, 8'h01, 16'hFFFF, 16'd0, 128, 4, 1'b0);
        rd_cap(cap); chk("R10 internal /128", cap, 128);
        meas(8'h00, 8'h00, 16'hFFFF, 16'd0, 40, 3, 1'b1);
        rd(T_STAT, d); chk("R10 pin disabled no capture", int'(d), 0);

        // R11 filter rejects a two-sample glitch, passes a real pulse
        setup(8'h20, 8'h04, 16'hFFFF, 16'd0);
        ref_pin = 1'b1; idle(10); ref_pin = 1'b0; idle(10);
        ref_pin = 1'b1; idle(2);  ref_pin = 1'b0; idle(20);
        rd(T_STAT, d); chk("R11 glitch rejected", int'(d[1]), 0);
        ref_pin = 1'b1; idle(10); ref_pin = 1'b0; idle(10);
        rd(T_STAT, d); chk("R11 real edge accepted", int'(d[1]), 1);
        meas(8'h20, 8'h0C, 16'hFFFF, 16'd0, 128, 3, 1'b1);
        rd_cap(cap); chk("R11 filter /16 period", cap, 128);

        // R7 overflow
        setup(8'h20, 8'h00, 16'hFFFF, 16'd0);
        ref_pin = 1'b1; idle(10); ref_pin = 1'b0;
        idle(65600);
        rd(T_STAT, d); chk("R7 overflow only", int'(d), 4);
        wr(T_IEN, 8'h04); chk("R9 ovf irq", int'(irq_ovf), 1);

        // R12 stop keeps flags, restart measures cleanly
        wr(T_CTRL, 8'h00);
        rd(T_STAT, d); chk("R12 flags kept on stop", int'(d), 4);
        meas(8'h20, 8'h00, 16'd100, 16'd0, 40, 3, 1'b1);
        rd_cap(cap); chk("R12 restart capture", cap, 40);
        rd(T_STAT, d); chk("R12 restart status", int'(d), 2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule